// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Interrupt Detection

This block manages a bank of general-purpose pins for software. A simple word-wide register bus (address, write enable, write data, combinational read data) reaches an output-data word, a direction word and two write-only words that set or clear output bits atomically. Input pins pass through a two-flop synchronizer, and the synchronized value can be read back. Two further words, for pull enable and pull type, are storage only.

Each pin can raise an interrupt in one of five trigger modes: rising edge, falling edge, either edge, high level or low level. Three configuration words choose the mode. Per pin, a detect/level select bit, a both-edges bit and a polarity bit are decoded into one of the enumerated trigger states `TRIG_RISE`, `TRIG_FALL`, `TRIG_BOTH`, `TRIG_HIGH` and `TRIG_LOW`. A pin moves from one trigger state to another only when software writes one of those words. The decode is: select=0 with both=0 gives `TRIG_RISE` for polarity 0 and `TRIG_FALL` for polarity 1. Select=0 with both=1 gives `TRIG_BOTH`. Select=1 gives `TRIG_HIGH` for polarity 0 and `TRIG_LOW` for polarity 1.

A detected event sets a sticky status bit only while that pin is enabled. Status bits are cleared by writing ones to the clear word. A mask word keeps a latched status bit from reaching the single combined interrupt output, but the bit itself still latches.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every register reads 0, and `pin_out`, `pin_oe` and `irq_o` are 0.
- R2: A write to offset 0x00 replaces the output word, which drives `pin_out` and reads back. A write to offset 0x08 sets direction, which drives `pin_oe`; a bit of 1 means output.
- R3: A write to offset 0x10 sets each output bit where the written bit is 1. A write to offset 0x14 clears each output bit where the written bit is 1. Bits written as 0 keep their value.
- R4: A read of offset 0x04 returns `pin_in` after two flops. A change made just after an edge is not visible after one edge and is visible after two edges.
- R5: In edge detection (offset 0x34 bit = 0) with offset 0x38 bit = 0, a polarity bit of 0 at offset 0x3C latches on a 0-to-1 pin change. A polarity bit of 1 latches on a 1-to-0 pin change.
- R6: In edge detection with offset 0x38 bit = 1, both pin changes latch, whatever the polarity bit holds.
- R7: In level detection (offset 0x34 bit = 1), status latches while the pin is high (polarity 0) or low (polarity 1). The both-edges bit has no effect.
- R8: A status bit at offset 0x24 can only become set while its enable bit at offset 0x20 is 1. Enabling a pin later does not latch an event that is already past.
- R9: Writing 1s to offset 0x30 clears those status bits and leaves the others alone. If a clear and a new event land in the same cycle, the event wins, so a held active level reads as set right after the clear.
- R10: `irq_o` is 1 exactly when some status bit is set with its enable 1 and its mask bit (offset 0x2C) 0. Masking does not stop a status bit from latching.
- R11: The pull-enable (0x18) and pull-type (0x1C) words store and read back any written value. The set, clear and status-clear offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 32 | Asynchronous pin inputs |
| pin_out | output | 32 | Output data word |
| pin_oe | output | 32 | Output enables (1 = drive) |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench steps through all eight combinations of the three mode bits, so it also covers the combinations where a bit should be ignored. For each combination it applies pairs of pseudo-random pin words across all 32 pins at once. The status read after each pair separates rising from falling from both-edge detection, because a pin that changed in only one direction latches under only one of those modes. Level modes are separated from edge modes because steady pins still latch in a level mode. Directed patterns then split a partial enable word, a partial clear word, masks that hide latched status, and a clear that collides with a held level.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int REG_AW = 8;

    localparam logic [REG_AW-1:0] OFS_DOUT  = 8'h00;
    localparam logic [REG_AW-1:0] OFS_DIN   = 8'h04;
    localparam logic [REG_AW-1:0] OFS_DIR   = 8'h08;
    localparam logic [REG_AW-1:0] OFS_DSET  = 8'h10;
    localparam logic [REG_AW-1:0] OFS_DCLR  = 8'h14;
    localparam logic [REG_AW-1:0] OFS_PEN   = 8'h18;
    localparam logic [REG_AW-1:0] OFS_PTYP  = 8'h1C;
    localparam logic [REG_AW-1:0] OFS_IEN   = 8'h20;
    localparam logic [REG_AW-1:0] OFS_ISTS  = 8'h24;
    localparam logic [REG_AW-1:0] OFS_IMSK  = 8'h2C;
    localparam logic [REG_AW-1:0] OFS_ICLR  = 8'h30;
    localparam logic [REG_AW-1:0] OFS_ISEL  = 8'h34;
    localparam logic [REG_AW-1:0] OFS_IBOTH = 8'h38;
    localparam logic [REG_AW-1:0] OFS_IPOL  = 8'h3C;

    typedef enum logic [2:0] {
        TRIG_RISE = 3'd0,
        TRIG_FALL = 3'd1,
        TRIG_BOTH = 3'd2,
        TRIG_HIGH = 3'd3,
        TRIG_LOW  = 3'd4
    } trig_mode_e;

    // Level select dominates; both-edges dominates polarity in edge mode.
    function automatic trig_mode_e decode_trig(input logic lvl_sel,
                                               input logic both,
                                               input logic pol);
        if (lvl_sel)   return pol ? TRIG_LOW : TRIG_HIGH;
        else if (both) return TRIG_BOTH;
        else           return pol ? TRIG_FALL : TRIG_RISE;
    endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int NPIN   = 32,
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pin_raw,
    output logic [NPIN-1:0] pin_cur,
    output logic [NPIN-1:0] pin_prev
);

    logic [NPIN-1:0] chain_q [STAGES];
    logic [NPIN-1:0] prev_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= '0;
                    else        chain_q[s] <= pin_raw;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= '0;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign pin_cur  = chain_q[STAGES-1];
    assign pin_prev = prev_q;

endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect
    import gpio_irq_pkg::*;
#(
    parameter int NPIN = 32
) (
    input  logic [NPIN-1:0] pin_cur,
    input  logic [NPIN-1:0] pin_prev,
    input  logic [NPIN-1:0] cfg_lvl,
    input  logic [NPIN-1:0] cfg_both,
    input  logic [NPIN-1:0] cfg_pol,
    output logic [NPIN-1:0] hit
);

    generate
        for (genvar p = 0; p < NPIN; p++) begin : g_pin
            trig_mode_e mode;
            logic       rise;
            logic       fall;

            assign rise = pin_cur[p] & ~pin_prev[p];
            assign fall = ~pin_cur[p] & pin_prev[p];

            always_comb begin
                mode = decode_trig(cfg_lvl[p], cfg_both[p], cfg_pol[p]);
                unique case (mode)
                    TRIG_RISE: hit[p] = rise;
                    TRIG_FALL: hit[p] = fall;
                    TRIG_BOTH: hit[p] = rise | fall;
                    TRIG_HIGH: hit[p] = pin_cur[p];
                    TRIG_LOW:  hit[p] = ~pin_cur[p];
                    default:   hit[p] = 1'b0;
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
    parameter int NPIN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] hit,
    input  logic [NPIN-1:0] enable,
    input  logic [NPIN-1:0] mask,
    input  logic            clr_we,
    input  logic [NPIN-1:0] clr_bits,
    output logic [NPIN-1:0] status,
    output logic            irq
);

    logic [NPIN-1:0] status_q;
    logic [NPIN-1:0] clr_vec;
    logic [NPIN-1:0] status_d;

    always_comb begin
        clr_vec  = clr_we ? clr_bits : '0;
        // A fresh event outranks a clear landing in the same cycle.
        status_d = (status_q & ~clr_vec) | (hit & enable);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_d;
    end

    assign status = status_q;
    assign irq    = |(status_q & enable & ~mask);

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int NPIN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [NPIN-1:0]   bus_wdata,
    output logic [NPIN-1:0]   bus_rdata,
    input  logic [NPIN-1:0]   pin_in,
    output logic [NPIN-1:0]   pin_out,
    output logic [NPIN-1:0]   pin_oe,
    output logic              irq_o
);

    logic [NPIN-1:0] dout_q, dir_q, pen_q, ptyp_q;
    logic [NPIN-1:0] ien_q, imsk_q, isel_q, iboth_q, ipol_q;
    logic [NPIN-1:0] pin_cur, pin_prev, hit, stat_q;
    logic            clr_we;

    gpio_pin_sync #(.NPIN(NPIN), .STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_raw  (pin_in),
        .pin_cur  (pin_cur),
        .pin_prev (pin_prev)
    );

    gpio_trig_detect #(.NPIN(NPIN)) u_detect (
        .pin_cur  (pin_cur),
        .pin_prev (pin_prev),
        .cfg_lvl  (isel_q),
        .cfg_both (iboth_q),
        .cfg_pol  (ipol_q),
        .hit      (hit)
    );

    assign clr_we = bus_we && (bus_addr == OFS_ICLR);

    gpio_irq_status #(.NPIN(NPIN)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (hit),
        .enable   (ien_q),
        .mask     (imsk_q),
        .clr_we   (clr_we),
        .clr_bits (bus_wdata),
        .status   (stat_q),
        .irq      (irq_o)
    );

    // Output word: full write, atomic set, atomic clear.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_q <= '0;
        end else if (bus_we) begin
            unique case (bus_addr)
                OFS_DOUT: dout_q <= bus_wdata;
                OFS_DSET: dout_q <= dout_q | bus_wdata;
                OFS_DCLR: dout_q <= dout_q & ~bus_wdata;
                default:  dout_q <= dout_q;
            endcase
        end
    end

    // Plain configuration words.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q   <= '0;
            pen_q   <= '0;
            ptyp_q  <= '0;
            ien_q   <= '0;
            imsk_q  <= '0;
            isel_q  <= '0;
            iboth_q <= '0;
            ipol_q  <= '0;
        end else if (bus_we) begin
            unique case (bus_addr)
                OFS_DIR:   dir_q   <= bus_wdata;
                OFS_PEN:   pen_q   <= bus_wdata;
                OFS_PTYP:  ptyp_q  <= bus_wdata;
                OFS_IEN:   ien_q   <= bus_wdata;
                OFS_IMSK:  imsk_q  <= bus_wdata;
                OFS_ISEL:  isel_q  <= bus_wdata;
                OFS_IBOTH: iboth_q <= bus_wdata;
                OFS_IPOL:  ipol_q  <= bus_wdata;
                default:   ;
            endcase
        end
    end

    always_comb begin
        unique case (bus_addr)
            OFS_DOUT:  bus_rdata = dout_q;
            OFS_DIN:   bus_rdata = pin_cur;
            OFS_DIR:   bus_rdata = dir_q;
            OFS_PEN:   bus_rdata = pen_q;
            OFS_PTYP:  bus_rdata = ptyp_q;
            OFS_IEN:   bus_rdata = ien_q;
            OFS_ISTS:  bus_rdata = stat_q;
            OFS_IMSK:  bus_rdata = imsk_q;
            OFS_ISEL:  bus_rdata = isel_q;
            OFS_IBOTH: bus_rdata = iboth_q;
            OFS_IPOL:  bus_rdata = ipol_q;
            default:   bus_rdata = '0;
        endcase
    end

    assign pin_out = dout_q;
    assign pin_oe  = dir_q;

endmodule

// File: rtl/gpio_irq_checker.sv
module gpio_irq_checker
    import gpio_irq_pkg::*;
#(
    parameter int NPIN = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [REG_AW-1:0] bus_addr,
    input logic              bus_we,
    input logic [NPIN-1:0]   bus_wdata,
    input logic [NPIN-1:0]   pin_out,
    input logic              irq_o,
    input logic [NPIN-1:0]   stat_q,
    input logic [NPIN-1:0]   ien_q,
    input logic [NPIN-1:0]   imsk_q
);

    logic [NPIN-1:0] clr_seen;
    assign clr_seen = (bus_we && bus_addr == OFS_ICLR) ? bus_wdata : '0;

    assert_dout_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_DOUT) |=> (pin_out == $past(bus_wdata)));

    assert_set_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_DSET) |=> ((pin_out & $past(bus_wdata)) == $past(bus_wdata)));

    assert_clear_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_DCLR) |=> ((pin_out & $past(bus_wdata)) == '0));

    assert_enable_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(ien_q)) == '0));

    assert_sticky_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(stat_q) & ~$past(clr_seen) & ~stat_q) == '0));

    assert_mask_hides_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((stat_q & ~imsk_q) != '0));

endmodule

bind gpio_irq_ctrl gpio_irq_checker #(.NPIN(NPIN)) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .pin_out   (pin_out),
    .irq_o     (irq_o),
    .stat_q    (stat_q),
    .ien_q     (ien_q),
    .imsk_q    (imsk_q)
);

// File: tb/gpio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_bench;
    import gpio_irq_pkg::*;

    localparam int NPIN = 32;
    localparam logic [NPIN-1:0] ONES = '1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [REG_AW-1:0] bus_addr = '0;
    logic              bus_we = 1'b0;
    logic [NPIN-1:0]   bus_wdata = '0;
    logic [NPIN-1:0]   bus_rdata;
    logic [NPIN-1:0]   pin_in = '0;
    logic [NPIN-1:0]   pin_out;
    logic [NPIN-1:0]   pin_oe;
    logic              irq_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    gpio_irq_ctrl #(.NPIN(NPIN)) u_gpio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [NPIN-1:0] got,
                         input logic [NPIN-1:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [REG_AW-1:0] a, input logic [NPIN-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [REG_AW-1:0] a, output logic [NPIN-1:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [NPIN-1:0] lfsr(input logic [NPIN-1:0] x);
        return {x[NPIN-2:0], x[31] ^ x[21] ^ x[1] ^ x[0]};
    endfunction

    // Expected status after pins go P -> N, status cleared while P was steady.
    function automatic logic [NPIN-1:0] model(input int m, input logic [NPIN-1:0] p,
                                              input logic [NPIN-1:0] n);
        if (m[2])      return m[0] ? (~p | ~n) : (p | n);
        else if (m[1]) return p ^ n;
        else           return m[0] ? (p & ~n) : (n & ~p);
    endfunction

    initial begin : watchdog
        #(5.0 * 200000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog got=running exp=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [NPIN-1:0] r, p, n, seed;
        logic [REG_AW-1:0] offs [14];
        offs = '{OFS_DOUT, OFS_DIN, OFS_DIR, OFS_DSET, OFS_DCLR, OFS_PEN, OFS_PTYP,
                 OFS_IEN, OFS_ISTS, OFS_IMSK, OFS_ICLR, OFS_ISEL, OFS_IBOTH, OFS_IPOL};

        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        for (int i = 0; i < 14; i++) begin
            rd(offs[i], r);
            check("R1 reg", r, '0);
        end
        check("R1 pin_out", pin_out, '0);
        check("R1 pin_oe", pin_oe, '0);
        check("R1 irq", {31'd0, irq_o}, '0);

        // R2 output word and direction
        wr(OFS_DOUT, 32'hA5A5_5A5A);
        rd(OFS_DOUT, r);
        check("R2 dout read", r, 32'hA5A5_5A5A);
        check("R2 pin_out", pin_out, 32'hA5A5_5A5A);
        wr(OFS_DIR, 32'h0F0F_00FF);
        rd(OFS_DIR, r);
        check("R2 dir read", r, 32'h0F0F_00FF);
        check("R2 pin_oe", pin_oe, 32'h0F0F_00FF);

        // R3 atomic set / clear
        wr(OFS_DSET, 32'h0000_00F0);
        check("R3 set", pin_out, 32'hA5A5_5AFA);
        wr(OFS_DCLR, 32'h8000_0042);
        check("R3 clear", pin_out, 32'h25A5_5AB8);
        wr(OFS_DSET, 32'h0);
        check("R3 set zero", pin_out, 32'h25A5_5AB8);

        // R11 pull storage and write-only offsets
        wr(OFS_PEN, 32'hDEAD_BEEF);
        wr(OFS_PTYP, 32'h1357_9BDF);
        rd(OFS_PEN, r);  check("R11 pull enable", r, 32'hDEAD_BEEF);
        rd(OFS_PTYP, r); check("R11 pull type", r, 32'h1357_9BDF);
        rd(OFS_DSET, r); check("R11 set reads 0", r, '0);
        rd(OFS_DCLR, r); check("R11 clear reads 0", r, '0);
        rd(OFS_ICLR, r); check("R11 iclr reads 0", r, '0);

        // R4 two-flop input latency
        @(negedge clk);
        pin_in = 32'h1234_5678;
        @(negedge clk);
        rd(OFS_DIN, r); check("R4 one edge", r, '0);
        @(negedge clk);
        rd(OFS_DIN, r); check("R4 two edges", r, 32'h1234_5678);

        // R5 R6 R7 sweep of all mode-bit combinations
        wr(OFS_IEN, ONES);
        wr(OFS_IMSK, '0);
        seed = 32'h1D87_2B41;
        for (int m = 0; m < 8; m++) begin
            wr(OFS_ISEL,  m[2] ? ONES : '0);
            wr(OFS_IBOTH, m[1] ? ONES : '0);
            wr(OFS_IPOL,  m[0] ? ONES : '0);
            for (int k = 0; k < 6; k++) begin
                p = seed; seed = lfsr(seed);
                n = seed; seed = lfsr(seed);
                @(negedge clk); pin_in = p;
                idle(4);
                wr(OFS_ICLR, ONES);
                idle(4);
                pin_in = n;
                idle(4);
                rd(OFS_ISTS, r);
                if (m[2])      check("R7 level", r, model(m, p, n));
                else if (m[1]) check("R6 both edges", r, model(m, p, n));
                else           check("R5 single edge", r, model(m, p, n));
                check("R10 irq follows status", {31'd0, irq_o},
                      {31'd0, model(m, p, n) != '0});
            end
        end

        // R8 enable gating
        wr(OFS_ISEL, '0); wr(OFS_IBOTH, '0); wr(OFS_IPOL, '0);
        @(negedge clk); pin_in = '0;
        idle(4);
        wr(OFS_IEN, 32'h0000_FFFF);
        wr(OFS_ICLR, ONES);
        pin_in = ONES;
        idle(4);
        rd(OFS_ISTS, r); check("R8 partial enable", r, 32'h0000_FFFF);
        wr(OFS_IEN, ONES);
        idle(2);
        rd(OFS_ISTS, r); check("R8 no late latch", r, 32'h0000_FFFF);

        // R9 partial clear
        wr(OFS_ICLR, 32'h0000_00FF);
        rd(OFS_ISTS, r); check("R9 partial clear", r, 32'h0000_FF00);
        wr(OFS_ICLR, ONES);
        rd(OFS_ISTS, r); check("R9 full clear", r, '0);

        // R10 mask
        pin_in = '0;
        idle(4);
        wr(OFS_IMSK, ONES);
        pin_in = 32'h0000_0008;
        idle(4);
        rd(OFS_ISTS, r); check("R10 masked latches", r, 32'h0000_0008);
        check("R10 masked irq", {31'd0, irq_o}, '0);
        wr(OFS_IMSK, 32'hFFFF_FFF7);
        check("R10 unmasked irq", {31'd0, irq_o}, 32'd1);
        wr(OFS_IEN, 32'hFFFF_FFF7);
        check("R10 disabled irq", {31'd0, irq_o}, '0);
        rd(OFS_ISTS, r); check("R10 status kept", r, 32'h0000_0008);

        // R9 clear colliding with a held high level
        wr(OFS_IEN, ONES); wr(OFS_IMSK, '0);
        wr(OFS_ISEL, ONES);
        pin_in = 32'h0000_0001;
        idle(4);
        wr(OFS_ICLR, ONES);
        rd(OFS_ISTS, r); check("R9 level wins clear", r, 32'h0000_0001);
        wr(OFS_ISEL, '0);
        wr(OFS_ICLR, ONES);
        rd(OFS_ISTS, r); check("R9 edge cleared", r, '0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule